// File: doc/BRIEF.md
# Sliding-Window Key/Value Slot Store

The block keeps the keys and values for a sliding attention window on chip. It has a fixed set of slots. Each slot holds one key row and the value row that goes with it, each of `ROW_LEN` elements. Every key/value row is streamed in exactly once, and after that it stays in its slot. Consumers read it there through a read port per slot, addressed by element index. Rows are never shifted between slots and never popped.

A query-row start strobe refreshes one slot per query row. The slot is chosen by a rotating pointer, and only one row's worth of data is loaded into it. Some slots can be pinned as global slots by a synthesis-time mask. These slots are filled once by a separate preload strobe before the run. The pointer skips them, so the rotation never overwrites them.

A busy output covers the time a refresh takes. A new row cannot start until the current refresh has finished. A per-slot valid flag lets consumers mask out slots that are still empty early in a sequence.

Top module: `kvw_slot_store`

## Requirements
- R1: After reset, `busy_o`, `ld_ready_o` and `ld_done_o` are low, every bit of `slot_vld_o` is 0, every stored element reads 0, and `rot_ptr_o` names the lowest-numbered non-global slot.
- R2: An accepted start raises `busy_o` and `ld_ready_o` in the next cycle and latches the target slot on `tgt_slot_o`. Each cycle with `ld_valid_i` high while `ld_ready_o` is high writes `ld_k_i` and `ld_v_i` into element 0, 1, … `ROW_LEN-1` of the key and value row of that slot, in order. Cycles with `ld_valid_i` low stall the fill.
- R3: A fill changes only its target slot; all other slots keep their contents.
- R4: Row starts are counted from 0 after reset. Row n fills the (n mod R)-th non-global slot, where R is the number of non-global slots and those slots are taken in ascending index order. `rot_ptr_o` always shows the slot the next row will use and changes only when a row start is accepted.
- R5: A slot whose bit in `GLOBAL_MASK` is 1 is never chosen by a row start.
- R6: When the block is idle, `glb_start_i` with `glb_slot_i` naming a global slot starts a fill of that slot. If `glb_slot_i` names a non-global slot, the strobe is ignored: `busy_o` stays low and the pointer is unchanged.
- R7: `row_start_i` and `glb_start_i` are ignored while `busy_o` is high. If both strobes arrive in the same idle cycle, the row start wins.
- R8: A slot's `slot_vld_o` bit is set when its first fill completes and stays set. Each slot's read port returns key and value element `rd_idx_i` of that slot combinationally.
- R9: `ld_valid_i` while `ld_ready_o` is low writes nothing.
- R10: `ld_done_o` pulses for exactly one cycle, in the cycle after the last element is written. `busy_o` falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| row_start_i | input | 1 | Query-row start strobe; refreshes the rotating slot |
| glb_start_i | input | 1 | Preload strobe for a global slot |
| glb_slot_i | input | SLOT_W | Slot index for a preload |
| ld_valid_i | input | 1 | Row element valid |
| ld_ready_o | output | 1 | Row element accepted |
| ld_k_i | input | DATA_W | Key element |
| ld_v_i | input | DATA_W | Value element |
| busy_o | output | 1 | Fill in progress |
| ld_done_o | output | 1 | One-cycle pulse when a slot fill completes |
| tgt_slot_o | output | SLOT_W | Slot being filled |
| rot_ptr_o | output | SLOT_W | Slot the next row start will fill |
| slot_vld_o | output | NUM_SLOTS | Per-slot valid flags |
| rd_idx_i | input | NUM_SLOTS*IDX_W | Per-slot element index for reads |
| rd_k_o | output | NUM_SLOTS*DATA_W | Per-slot key element |
| rd_v_o | output | NUM_SLOTS*DATA_W | Per-slot value element |

## Verification
Fills are streamed with random data and random valid gaps. This separates element ordering from cycle counting, and random data shows a write landing in the wrong slot or at the wrong element. Many row starts run, more than the rotating slots in number. They show whether the pointer wraps and skips the pinned slots, and whether the pinned slots survive the rotation. Directed cases cover the ignored inputs: a strobe during a fill, a preload aimed at a rotating slot, and data offered while idle. They also cover both strobes arriving at once, which tells the priority apart from a merged or lost start.

// File: rtl/kvw_pkg.sv
package kvw_pkg;
  typedef enum logic {ST_IDLE, ST_FILL} fill_st_e;
endpackage

// File: rtl/kvw_slot.sv
module kvw_slot #(
  parameter int ROW_LEN = 8,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = $clog2(ROW_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_last_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_k_i,
  input  logic [DATA_W-1:0] wr_v_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_k_o,
  output logic [DATA_W-1:0] rd_v_o,
  output logic              vld_o
);
  logic [DATA_W-1:0] k_q [ROW_LEN];
  logic [DATA_W-1:0] v_q [ROW_LEN];
  logic              vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < ROW_LEN; e++) begin
        k_q[e] <= '0;
        v_q[e] <= '0;
      end
      vld_q <= 1'b0;
    end else if (wr_en_i) begin
      k_q[wr_idx_i] <= wr_k_i;
      v_q[wr_idx_i] <= wr_v_i;
      if (wr_last_i) vld_q <= 1'b1;
    end
  end

  assign rd_k_o = k_q[rd_idx_i];
  assign rd_v_o = v_q[rd_idx_i];
  assign vld_o  = vld_q;

  AST_SLOT_VLD_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |=> vld_q); // R8
endmodule

// File: rtl/kvw_rot_ptr.sv
module kvw_rot_ptr #(
  parameter int NUM_SLOTS = 8,
  parameter logic [NUM_SLOTS-1:0] GLOBAL_MASK = 8'h01,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [SLOT_W-1:0] ptr_o
);
  function automatic logic [SLOT_W-1:0] first_rot();
    for (int s = NUM_SLOTS - 1; s >= 0; s--)
      if (!GLOBAL_MASK[s]) first_rot = SLOT_W'(s);
  endfunction

  localparam logic [SLOT_W-1:0] PTR_RST = first_rot();

  logic [SLOT_W-1:0] ptr_q, ptr_nxt;

  // next non-global slot after ptr_q, wrapping
  always_comb begin
    logic found;
    found   = 1'b0;
    ptr_nxt = ptr_q;
    for (int k = 1; k <= NUM_SLOTS; k++) begin
      int c;
      c = (int'(ptr_q) + k) % NUM_SLOTS;
      if (!found && !GLOBAL_MASK[c]) begin
        ptr_nxt = SLOT_W'(c);
        found   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= PTR_RST;
    else if (adv_i) ptr_q <= ptr_nxt;
  end

  assign ptr_o = ptr_q;

  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_q)); // R4
  AST_PTR_NOT_GLOBAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> !GLOBAL_MASK[ptr_q]); // R5
endmodule

// File: rtl/kvw_fill_ctrl.sv
module kvw_fill_ctrl import kvw_pkg::*; #(
  parameter int ROW_LEN = 8,
  parameter int SLOT_W  = 3,
  localparam int IDX_W  = $clog2(ROW_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              row_start_i,
  input  logic              glb_start_i,
  input  logic [SLOT_W-1:0] glb_slot_i,
  input  logic              glb_ok_i,
  input  logic [SLOT_W-1:0] rot_slot_i,
  input  logic              ld_valid_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [SLOT_W-1:0] tgt_slot_o,
  output logic              wr_en_o,
  output logic              wr_last_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic              adv_o
);
  fill_st_e          st_q;
  logic [IDX_W-1:0]  cnt_q;
  logic [SLOT_W-1:0] tgt_q;
  logic              done_q;
  logic              idle, glb_acc;

  assign idle      = (st_q == ST_IDLE);
  assign adv_o     = idle && row_start_i;
  assign glb_acc   = idle && !row_start_i && glb_start_i && glb_ok_i;
  assign wr_en_o   = (st_q == ST_FILL) && ld_valid_i;
  assign wr_last_o = (cnt_q == IDX_W'(ROW_LEN - 1));
  assign wr_idx_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      tgt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= wr_en_o && wr_last_o;
      unique case (st_q)
        ST_IDLE: begin
          if (adv_o) begin
            tgt_q <= rot_slot_i;
            cnt_q <= '0;
            st_q  <= ST_FILL;
          end else if (glb_acc) begin
            tgt_q <= glb_slot_i;
            cnt_q <= '0;
            st_q  <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (wr_en_o) begin
            if (wr_last_o) begin
              cnt_q <= '0;
              st_q  <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q == ST_FILL);
  assign done_o     = done_q;
  assign tgt_slot_o = tgt_q;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) < ROW_LEN); // R2
  AST_DONE_ENDS_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!busy_o && $past(busy_o))); // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R10
  AST_TGT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(tgt_q)); // R2
endmodule

// File: rtl/kvw_slot_store.sv
module kvw_slot_store #(
  parameter int NUM_SLOTS = 8,
  parameter int ROW_LEN   = 8,
  parameter int DATA_W    = 16,
  parameter logic [NUM_SLOTS-1:0] GLOBAL_MASK = 8'h01,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int IDX_W  = $clog2(ROW_LEN)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        row_start_i,
  input  logic                        glb_start_i,
  input  logic [SLOT_W-1:0]           glb_slot_i,
  input  logic                        ld_valid_i,
  output logic                        ld_ready_o,
  input  logic [DATA_W-1:0]           ld_k_i,
  input  logic [DATA_W-1:0]           ld_v_i,
  output logic                        busy_o,
  output logic                        ld_done_o,
  output logic [SLOT_W-1:0]           tgt_slot_o,
  output logic [SLOT_W-1:0]           rot_ptr_o,
  output logic [NUM_SLOTS-1:0]        slot_vld_o,
  input  logic [NUM_SLOTS*IDX_W-1:0]  rd_idx_i,
  output logic [NUM_SLOTS*DATA_W-1:0] rd_k_o,
  output logic [NUM_SLOTS*DATA_W-1:0] rd_v_o
);
  logic              glb_ok, adv, wr_en, wr_last, busy, tgt_glb;
  logic [IDX_W-1:0]  wr_idx;
  logic [SLOT_W-1:0] rot_ptr, tgt;
  logic [NUM_SLOTS-1:0] slot_we;

  always_comb begin
    glb_ok  = 1'b0;
    tgt_glb = 1'b0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (glb_slot_i == SLOT_W'(s) && GLOBAL_MASK[s]) glb_ok = 1'b1;
      if (tgt == SLOT_W'(s) && GLOBAL_MASK[s])        tgt_glb = 1'b1;
    end
  end

  kvw_rot_ptr #(
    .NUM_SLOTS   (NUM_SLOTS),
    .GLOBAL_MASK (GLOBAL_MASK)
  ) u_rot_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .ptr_o  (rot_ptr)
  );

  kvw_fill_ctrl #(
    .ROW_LEN (ROW_LEN),
    .SLOT_W  (SLOT_W)
  ) u_fill_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .row_start_i (row_start_i),
    .glb_start_i (glb_start_i),
    .glb_slot_i  (glb_slot_i),
    .glb_ok_i    (glb_ok),
    .rot_slot_i  (rot_ptr),
    .ld_valid_i  (ld_valid_i),
    .busy_o      (busy),
    .done_o      (ld_done_o),
    .tgt_slot_o  (tgt),
    .wr_en_o     (wr_en),
    .wr_last_o   (wr_last),
    .wr_idx_o    (wr_idx),
    .adv_o       (adv)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign slot_we[s] = wr_en && (tgt == SLOT_W'(s));

    kvw_slot #(
      .ROW_LEN (ROW_LEN),
      .DATA_W  (DATA_W)
    ) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (slot_we[s]),
      .wr_last_i (wr_last),
      .wr_idx_i  (wr_idx),
      .wr_k_i    (ld_k_i),
      .wr_v_i    (ld_v_i),
      .rd_idx_i  (rd_idx_i[s*IDX_W +: IDX_W]),
      .rd_k_o    (rd_k_o[s*DATA_W +: DATA_W]),
      .rd_v_o    (rd_v_o[s*DATA_W +: DATA_W]),
      .vld_o     (slot_vld_o[s])
    );
  end

  assign busy_o     = busy;
  assign ld_ready_o = busy;
  assign tgt_slot_o = tgt;
  assign rot_ptr_o  = rot_ptr;

  AST_ONE_SLOT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(slot_we)); // R3
  AST_ROW_NOT_GLOBAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv |=> !tgt_glb); // R5
  AST_NO_WRITE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (slot_we == '0)); // R9
  AST_VLD_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(slot_vld_o) & ~slot_vld_o) == '0); // R8
endmodule

// File: tb/kvw_slot_store_tb.sv
module kvw_slot_store_tb_top;
  localparam int NS = 6;
  localparam int RL = 4;
  localparam int DW = 8;
  localparam logic [NS-1:0] GM = 6'b000101;
  localparam int SW = $clog2(NS);
  localparam int IW = $clog2(RL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic row_start = 0, glb_start = 0, ld_valid = 0;
  logic [SW-1:0] glb_slot = '0;
  logic [DW-1:0] ld_k = '0, ld_v = '0;
  logic ld_ready, busy, ld_done;
  logic [SW-1:0] tgt_slot, rot_ptr;
  logic [NS-1:0] slot_vld;
  logic [NS*IW-1:0] rd_idx = '0;
  logic [NS*DW-1:0] rd_k, rd_v;

  kvw_slot_store #(.NUM_SLOTS(NS), .ROW_LEN(RL), .DATA_W(DW), .GLOBAL_MASK(GM)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .row_start_i(row_start), .glb_start_i(glb_start),
    .glb_slot_i(glb_slot), .ld_valid_i(ld_valid), .ld_ready_o(ld_ready),
    .ld_k_i(ld_k), .ld_v_i(ld_v), .busy_o(busy), .ld_done_o(ld_done),
    .tgt_slot_o(tgt_slot), .rot_ptr_o(rot_ptr), .slot_vld_o(slot_vld),
    .rd_idx_i(rd_idx), .rd_k_o(rd_k), .rd_v_o(rd_v));

  int total = 0, bad = 0;
  logic [DW-1:0] m_k [NS][RL];
  logic [DW-1:0] m_v [NS][RL];
  logic [NS-1:0] m_vld;
  int m_ptr;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int next_rot(input int p);
    for (int k = 1; k <= NS; k++)
      if (!GM[(p + k) % NS]) return (p + k) % NS;
    return p;
  endfunction

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // compare every element of every slot and the valid flags
  task automatic check_all(input string req);
    for (int e = 0; e < RL; e++) begin
      @(negedge clk);
      for (int s = 0; s < NS; s++) rd_idx[s*IW +: IW] = IW'(e);
      #1;
      for (int s = 0; s < NS; s++) begin
        chk(rd_k[s*DW +: DW] == m_k[s][e], req, int'(rd_k[s*DW +: DW]), int'(m_k[s][e]));
        chk(rd_v[s*DW +: DW] == m_v[s][e], req, int'(rd_v[s*DW +: DW]), int'(m_v[s][e]));
      end
    end
    chk(slot_vld == m_vld, "R8", int'(slot_vld), int'(m_vld));
  endtask

  // is_row: row start; else preload glb_sl. both: raise both strobes. inject: strobe during fill
  task automatic do_fill(input bit is_row, input int glb_sl, input bit both, input bit inject);
    int exp_slot, e;
    bit v;
    exp_slot = is_row ? m_ptr : glb_sl;
    @(negedge clk);
    row_start = is_row;
    glb_start = !is_row || both;
    glb_slot  = SW'(glb_sl);
    @(negedge clk);
    row_start = 0;
    glb_start = 0;
    if (is_row) m_ptr = next_rot(m_ptr);
    chk(busy && ld_ready, "R2", int'(busy), 1);
    chk(int'(tgt_slot) == exp_slot, both ? "R7" : (is_row ? "R4" : "R6"), int'(tgt_slot), exp_slot);
    chk(!GM[tgt_slot] || !is_row, "R5", int'(tgt_slot), exp_slot);
    e = 0;
    while (e < RL) begin
      v = ($urandom % 3) != 0;
      ld_valid = v;
      ld_k = DW'($urandom);
      ld_v = DW'($urandom);
      if (inject && e == 1) begin
        row_start = 1;
        glb_start = 1;
        glb_slot  = 0;
      end
      @(negedge clk);
      row_start = 0;
      glb_start = 0;
      if (v) begin
        m_k[exp_slot][e] = ld_k;
        m_v[exp_slot][e] = ld_v;
        e++;
        if (e < RL) chk(ld_done == 0, "R10", int'(ld_done), 0);
      end
    end
    ld_valid = 0;
    m_vld[exp_slot] = 1'b1;
    chk(ld_done == 1, "R10", int'(ld_done), 1);
    chk(busy == 0, "R10", int'(busy), 0);
    if (inject) chk(int'(rot_ptr) == m_ptr, "R7", int'(rot_ptr), m_ptr);
    @(negedge clk);
    chk(ld_done == 0, "R10", int'(ld_done), 0);
    chk(busy == 0, "R7", int'(busy), 0);
    chk(int'(rot_ptr) == m_ptr, "R4", int'(rot_ptr), m_ptr);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int s = 0; s < NS; s++)
      for (int e = 0; e < RL; e++) begin
        m_k[s][e] = '0;
        m_v[s][e] = '0;
      end
    m_vld = '0;
    m_ptr = next_rot(NS - 1);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !ld_ready && !ld_done, "R1", int'({busy, ld_ready, ld_done}), 0);
    chk(int'(rot_ptr) == m_ptr, "R1", int'(rot_ptr), m_ptr);
    chk(slot_vld == '0, "R1", int'(slot_vld), 0);
    check_all("R1");

    // R9 data offered while idle
    @(negedge clk);
    ld_valid = 1; ld_k = 8'hA5; ld_v = 8'h5A;
    @(negedge clk);
    chk(ld_ready == 0, "R9", int'(ld_ready), 0);
    ld_valid = 0;
    check_all("R9");

    // R6 preload aimed at a rotating slot is ignored
    @(negedge clk);
    glb_start = 1; glb_slot = 3'd1;
    @(negedge clk);
    glb_start = 0;
    chk(busy == 0, "R6", int'(busy), 0);
    chk(int'(rot_ptr) == m_ptr, "R6", int'(rot_ptr), m_ptr);
    check_all("R6");

    // R6 preload both global slots
    do_fill(0, 0, 0, 0);
    check_all("R3");
    do_fill(0, 2, 0, 0);
    check_all("R3");

    // R4 R5 rotation, longer than the window
    for (int r = 0; r < 10; r++) begin
      do_fill(1, 0, 0, (r == 3));
      check_all("R3");
    end

    // R7 both strobes at once: row start wins
    do_fill(1, 2, 1, 0);
    check_all("R7");

    finish_run();
  end
endmodule